// File: doc/BRIEF.md
# I2C Pin Recovery Multiplexer

This block sits between an I2C controller engine and the two open-drain bus lines, SCL and SDA. In normal operation the engine decides when each line is pulled low. When a target device holds the bus stuck, software can take both lines over as general-purpose I/O and clock SCL by hand until the bus is released. Software controls this through a small register port. One mode bit selects the owner of both lines. A direction register enables the low driver of each line. A level register returns the synchronized pin states. The output latch is changed through separate write-one-to-set and write-one-to-clear registers, so each line can be changed without a read-modify-write.

A typical sequence follows. Software first makes SCL an output and leaves SDA as an input. It then turns GPIO mode on and pulses SCL through the set and clear registers, reading SDA each time. At the end it writes 0 to the mode register, which hands the lines back to the engine. The GPIO registers keep their values across the handover, so the same setup can be used again without rewriting it.

Top module: `i2c_pin_recovery_mux`

## Requirements
- R1: After reset, the mode register and the direction register read 0. The latch reads 3, meaning both latches are high. The level register reads 3 while both pins are high.
- R2: While mode bit 0 is 0, `scl_pull_low` equals `eng_scl_pull` and `sda_pull_low` equals `eng_sda_pull`, whatever the direction and latch registers hold.
- R3: While mode bit 0 is 1, both lines are driven from the GPIO registers and the engine pull requests have no effect. The mode register is at address 0.
- R4: In GPIO mode a line is pulled low only when its direction bit is 1 and its latch bit is 0. Otherwise it is released. The direction register is at address 1, with bit 0 for SCL and bit 1 for SDA.
- R5: Writing to the set register (address 3) makes each latch bit that is written as 1 high: bit 0 for SCL, bit 1 for SDA. Latch bits written as 0 keep their value. The set and clear addresses both read back the current latch.
- R6: Writing to the clear register (address 4) makes each latch bit that is written as 1 low: bit 0 for SCL, bit 1 for SDA. Latch bits written as 0 keep their value.
- R7: The level register (address 2) returns SCL in bit 0 and SDA in bit 1. Each level passes through two flops, so a pin change made between clock edges shows up after the second rising edge and not earlier.
- R8: Writing 0 to the mode register returns both lines to the engine in the next cycle. The direction and latch values are kept, and they take effect again when GPIO mode is turned back on.
- R9: The level register is read-only. A write to address 2, or to any address above 4, changes no register.
- R10: Register bits above the defined fields are ignored on write and read as 0. An unmapped address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` (combinational) |
| eng_scl_pull | input | 1 | Engine request to pull SCL low |
| eng_sda_pull | input | 1 | Engine request to pull SDA low |
| scl_pin_in | input | 1 | SCL pin level |
| sda_pin_in | input | 1 | SDA pin level |
| scl_pull_low | output | 1 | Open-drain enable for SCL (1 = drive low) |
| sda_pull_low | output | 1 | Open-drain enable for SDA (1 = drive low) |

## Verification
The bench checks the ownership handover in both directions. A mux with its select inverted, or one that leaves the engine still able to pull a line in GPIO mode, would drive the bus while software believes it owns it. It checks that zero bits written to the set and clear registers leave the other line untouched; a design that wrote the latch directly would release SDA while pulsing SCL. It samples the level register one edge and two edges after a pin change, which catches a synchronizer with too few or too many stages. It also checks that an input-direction line stays released even when its latch is 0; a design that got this wrong would hold SDA low during recovery.

// File: rtl/i2c_pinmux_pkg.sv
package i2c_pinmux_pkg;

    localparam int LINES   = 2;
    localparam int SCL_IDX = 0;
    localparam int SDA_IDX = 1;

    // register addresses
    localparam int RA_MODE  = 0;
    localparam int RA_DIR   = 1;
    localparam int RA_LEVEL = 2;
    localparam int RA_SET   = 3;
    localparam int RA_CLR   = 4;

    typedef struct packed {
        logic             gpio_mode;
        logic [LINES-1:0] dir;
        logic [LINES-1:0] latch;
    } pin_ctl_t;

    localparam pin_ctl_t CTL_RESET = '{gpio_mode: 1'b0, dir: '0, latch: '1};

endpackage

// File: rtl/pinmux_ctl_regs.sv
module pinmux_ctl_regs
    import i2c_pinmux_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output pin_ctl_t          ctl
);

    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(RA_MODE);
    localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(RA_DIR);
    localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(RA_SET);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(RA_CLR);

    pin_ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (we) begin
            unique case (addr)
                A_MODE:  ctl_d.gpio_mode = wdata[0];
                A_DIR:   ctl_d.dir       = wdata[LINES-1:0];
                A_SET:   ctl_d.latch     = ctl_q.latch | wdata[LINES-1:0];
                A_CLR:   ctl_d.latch     = ctl_q.latch & ~wdata[LINES-1:0];
                default: ctl_d           = ctl_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= CTL_RESET;
        else        ctl_q <= ctl_d;
    end

    assign ctl = ctl_q;

endmodule

// File: rtl/pinmux_sync.sv
module pinmux_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/pinmux_od_drive.sv
module pinmux_od_drive
    import i2c_pinmux_pkg::*;
(
    input  pin_ctl_t         ctl,
    input  logic [LINES-1:0] eng_pull,
    output logic [LINES-1:0] pull_low
);

    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic gpio_pull;
        assign gpio_pull   = ctl.dir[i] & ~ctl.latch[i];
        assign pull_low[i] = ctl.gpio_mode ? gpio_pull : eng_pull[i];
    end

endmodule

// File: rtl/i2c_pin_recovery_mux.sv
module i2c_pin_recovery_mux
    import i2c_pinmux_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              eng_scl_pull,
    input  logic              eng_sda_pull,
    input  logic              scl_pin_in,
    input  logic              sda_pin_in,
    output logic              scl_pull_low,
    output logic              sda_pull_low
);

    localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(RA_MODE);
    localparam logic [ADDR_W-1:0] A_DIR   = ADDR_W'(RA_DIR);
    localparam logic [ADDR_W-1:0] A_LEVEL = ADDR_W'(RA_LEVEL);
    localparam logic [ADDR_W-1:0] A_SET   = ADDR_W'(RA_SET);
    localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(RA_CLR);

    pin_ctl_t         ctl_q;
    logic [LINES-1:0] level_sync;
    logic [LINES-1:0] pull_vec;
    logic [LINES-1:0] eng_vec;
    logic [LINES-1:0] pin_vec;

    assign eng_vec[SCL_IDX] = eng_scl_pull;
    assign eng_vec[SDA_IDX] = eng_sda_pull;
    assign pin_vec[SCL_IDX] = scl_pin_in;
    assign pin_vec[SDA_IDX] = sda_pin_in;

    pinmux_ctl_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .ctl   (ctl_q)
    );

    pinmux_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_vec),
        .sync_out (level_sync)
    );

    pinmux_od_drive u_drive (
        .ctl      (ctl_q),
        .eng_pull (eng_vec),
        .pull_low (pull_vec)
    );

    assign scl_pull_low = pull_vec[SCL_IDX];
    assign sda_pull_low = pull_vec[SDA_IDX];

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_MODE:         reg_rdata[0]       = ctl_q.gpio_mode;
            A_DIR:          reg_rdata[LINES-1:0] = ctl_q.dir;
            A_LEVEL:        reg_rdata[LINES-1:0] = level_sync;
            A_SET, A_CLR:   reg_rdata[LINES-1:0] = ctl_q.latch;
            default:        reg_rdata          = '0;
        endcase
    end

endmodule

// File: rtl/pinmux_chk.sv
module pinmux_chk
    import i2c_pinmux_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              eng_scl_pull,
    input logic              eng_sda_pull,
    input logic              scl_pin_in,
    input logic              sda_pin_in,
    input logic              scl_pull_low,
    input logic              sda_pull_low,
    input logic              gpio_on,
    input logic [LINES-1:0]  dir_bits
);

    logic [1:0] up_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)            up_cnt <= '0;
        else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
    end

    a_r2_engine_follow: assert property (@(posedge clk) disable iff (!rst_n)
        !gpio_on |-> (scl_pull_low == eng_scl_pull) && (sda_pull_low == eng_sda_pull));

    a_r4_input_released: assert property (@(posedge clk) disable iff (!rst_n)
        gpio_on && !dir_bits[SDA_IDX] |-> !sda_pull_low);

    a_r6_clear_pulls: assert property (@(posedge clk) disable iff (!rst_n)
        gpio_on && dir_bits[SCL_IDX] && reg_we && reg_addr == ADDR_W'(RA_CLR) && reg_wdata[SCL_IDX]
        |=> scl_pull_low);

    a_r5_set_releases: assert property (@(posedge clk) disable iff (!rst_n)
        gpio_on && reg_we && reg_addr == ADDR_W'(RA_SET) && reg_wdata[SCL_IDX]
        |=> !scl_pull_low);

    a_r7_level_sync: assert property (@(posedge clk) disable iff (!rst_n)
        up_cnt == 2'd3 && reg_addr == ADDR_W'(RA_LEVEL)
        |-> reg_rdata[1:0] == {$past(sda_pin_in, 2), $past(scl_pin_in, 2)});

    a_r10_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DATA_W-1:LINES] == '0);

endmodule

bind i2c_pin_recovery_mux pinmux_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_we       (reg_we),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .eng_scl_pull (eng_scl_pull),
    .eng_sda_pull (eng_sda_pull),
    .scl_pin_in   (scl_pin_in),
    .sda_pin_in   (sda_pin_in),
    .scl_pull_low (scl_pull_low),
    .sda_pull_low (sda_pull_low),
    .gpio_on      (ctl_q.gpio_mode),
    .dir_bits     (ctl_q.dir)
);

// File: tb/i2c_pin_recovery_mux_test.sv
module i2c_pin_recovery_mux_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        eng_scl_pull = 1'b0;
    logic        eng_sda_pull = 1'b0;
    logic        scl_pin_in = 1'b1;
    logic        sda_pin_in = 1'b1;
    logic        scl_pull_low;
    logic        sda_pull_low;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    i2c_pin_recovery_mux uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_scl_pull(eng_scl_pull), .eng_sda_pull(eng_sda_pull),
        .scl_pin_in(scl_pin_in), .sda_pin_in(sda_pin_in),
        .scl_pull_low(scl_pull_low), .sda_pull_low(sda_pull_low)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a[2:0]; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input int a, output logic [15:0] d);
        reg_addr = a[2:0];
        #1 d = reg_rdata;
    endtask

    function automatic logic [15:0] pulls();
        return {14'd0, sda_pull_low, scl_pull_low};
    endfunction

    task automatic t_reset();
        logic [15:0] v;
        rd(0, v); check("R1 mode", v, 16'h0);
        rd(1, v); check("R1 dir", v, 16'h0);
        rd(3, v); check("R1 latch", v, 16'h3);
        rd(2, v); check("R1 level", v, 16'h3);
    endtask

    task automatic t_engine_path();
        wr(1, 16'h3); wr(4, 16'h3);   // GPIO would pull both, but mode is 0
        for (int p = 0; p < 4; p++) begin
            eng_scl_pull = p[0]; eng_sda_pull = p[1];
            #1 check("R2 engine pulls", pulls(), 16'(p));
        end
        eng_scl_pull = 0; eng_sda_pull = 0;
        wr(3, 16'h3); wr(1, 16'h0);
    endtask

    task automatic t_handover();
        wr(1, 16'h1);                 // SCL out, SDA in
        wr(4, 16'h1);                 // SCL latch low
        eng_scl_pull = 0; eng_sda_pull = 1;
        wr(0, 16'h1);
        #1 check("R3 gpio owns lines", pulls(), 16'h1);
        eng_scl_pull = 1; eng_sda_pull = 1;
        #1 check("R3 engine ignored", pulls(), 16'h1);
        eng_scl_pull = 0; eng_sda_pull = 0;
        wr(4, 16'h2);                 // SDA latch low but SDA is input
        #1 check("R4 input released", pulls(), 16'h1);
        wr(1, 16'h3);
        #1 check("R4 output pulls", pulls(), 16'h3);
    endtask

    task automatic t_set_clear();
        logic [15:0] v;
        // both latches low, both outputs, gpio mode
        wr(3, 16'h1);
        #1 check("R5 set SCL only", pulls(), 16'h2);
        rd(4, v); check("R5 latch readback", v, 16'h1);
        wr(3, 16'h0);
        rd(3, v); check("R5 zero set no change", v, 16'h1);
        wr(3, 16'h2);
        #1 check("R5 set SDA", pulls(), 16'h0);
        wr(4, 16'h2);
        #1 check("R6 clear SDA only", pulls(), 16'h2);
        wr(4, 16'h0);
        rd(3, v); check("R6 zero clear no change", v, 16'h1);
        wr(4, 16'h1);
        #1 check("R6 clear SCL", pulls(), 16'h3);
    endtask

    task automatic t_return_engine();
        logic [15:0] v;
        eng_scl_pull = 0; eng_sda_pull = 1;
        wr(0, 16'h0);
        #1 check("R8 engine back", pulls(), 16'h2);
        rd(1, v); check("R8 dir kept", v, 16'h3);
        rd(3, v); check("R8 latch kept", v, 16'h0);
        eng_sda_pull = 0;
        wr(0, 16'h1);
        #1 check("R8 gpio resumes", pulls(), 16'h3);
        wr(0, 16'h0); wr(3, 16'h3);
    endtask

    task automatic t_level_sync();
        logic [15:0] v;
        @(negedge clk);
        scl_pin_in = 0; sda_pin_in = 1;
        rd(2, v); check("R7 level before edge", v, 16'h3);
        @(negedge clk);
        rd(2, v); check("R7 level after one edge", v, 16'h3);
        @(negedge clk);
        rd(2, v); check("R7 SCL bit0 after two edges", v, 16'h2);
        scl_pin_in = 1; sda_pin_in = 0;
        @(negedge clk); @(negedge clk);
        rd(2, v); check("R7 SDA bit1", v, 16'h1);
        sda_pin_in = 1;
        @(negedge clk); @(negedge clk);
    endtask

    task automatic t_readonly_upper();
        logic [15:0] v;
        wr(2, 16'h0);
        wr(5, 16'hFFFF); wr(7, 16'hFFFF);
        rd(2, v); check("R9 level unwritten", v, 16'h3);
        rd(0, v); check("R9 mode unchanged", v, 16'h0);
        rd(1, v); check("R9 dir unchanged", v, 16'h3);
        rd(3, v); check("R9 latch unchanged", v, 16'h3);
        wr(0, 16'hFFFE);
        rd(0, v); check("R10 upper mode bits ignored", v, 16'h0);
        wr(1, 16'hFFF0);
        rd(1, v); check("R10 upper dir bits ignored", v, 16'h0);
        rd(6, v); check("R10 unmapped reads 0", v, 16'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_engine_path();
        t_handover();
        t_set_clear();
        t_return_engine();
        t_level_sync();
        t_readonly_upper();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule